// File: doc/BRIEF.md
# Read-Capture Calibration Sweeper

This block chooses the read-capture setting for a serial memory interface. On a start request it steps through candidate settings 0 to N-1 in order. For each candidate it announces the index to an external read port with a one-cycle request. It then takes a fixed-length test burst, one byte per valid/ready beat, and checks every byte against a built-in reference pattern. A candidate passes only when the whole burst matches.

After the last candidate, the block scans the pass bits in index order. It looks for the longest unbroken run of passing candidates and records where that run ends. It then applies acceptance bands that depend on the capture mode. Double-rate and single-rate mode each have their own band and their own offset from the run end. If the run is too short or too long, the block falls back to a caller-supplied default index and raises a fail flag. The chosen index and the flag are held until the next sweep completes, so surrounding logic can apply the setting directly.

Top module: `rdcal_engine`

## Requirements
- R1: After reset, busy_o, done_o, rd_req_o, rd_ready_o, fail_o are 0 and sel_idx_o is 0.
- R2: start_i sampled high while idle begins a sweep: busy_o rises next cycle. For each candidate, in order 0..N-1, rd_req_o is high for exactly one cycle with trial_idx_o equal to that candidate, followed by a receive phase. start_i is ignored while busy_o is high.
- R3: During a receive phase rd_ready_o is high and a beat is taken on each cycle with rd_valid_i high. Beat b must equal byte b mod 4 of the word 0xA5FF005A taken least-significant byte first (0x5A, 0x00, 0xFF, 0xA5, repeating). A candidate passes only if all BURST_LEN beats match. After a mismatch the remaining beats of the burst are still consumed.
- R4: The run search walks pass bits from index 0 upward. When a failing index ends a run strictly longer than the best so far, the end index becomes that failing index minus 1. The reported length is the larger of the final open run and the best closed run. A trailing run that is longest but not the whole set leaves the end index unchanged.
- R5: When all N candidates pass, the end index used for selection is N.
- R6: With dbl_rate_i=1, a length of 2 or less, or 6 or more, selects dflt_idx_i and sets fail_o. A length of 3 or 4 selects end-1, and a length of 5 selects end-2.
- R7: With dbl_rate_i=0, a length of 2 or less, or 5 or more, selects dflt_idx_i and sets fail_o. Otherwise the block selects end minus length/2, rounded down.
- R8: done_o is a one-cycle pulse, N+1 cycles after the last beat is taken, with busy_o low. sel_idx_o and fail_o change only at that pulse.
- R9: Pass results are cleared at each start, so a sweep's outcome does not depend on earlier sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sweep when idle |
| dbl_rate_i | input | 1 | 1 = double-rate selection rules, 0 = single-rate |
| cand_cnt_i | input | CNTW | Candidate count N (1..MAX_CAND), stable during a sweep |
| dflt_idx_i | input | IDXW | Fallback index |
| rd_req_o | output | 1 | One-cycle request for a test burst |
| trial_idx_o | output | IDXW | Candidate setting under test |
| rd_valid_i | input | 1 | Read data beat valid |
| rd_data_i | input | 8 | Read data byte |
| rd_ready_o | output | 1 | Beat accept |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Result pulse |
| sel_idx_o | output | IDXW | Selected setting index |
| fail_o | output | 1 | Fallback was taken |

## Verification
The hardest case to reach from the ports is the run-search quirk. There, the trailing run is the longest but the recorded end index still belongs to an earlier, shorter run. A closely related case is a later run equal in length to an earlier one, which must not replace it. The bench reaches both by choosing which candidates receive a corrupted byte. The corrupted beat differs per candidate, so first, middle and last beats are all exercised. Some sweeps insert valid gaps, and one holds start high through the first burst.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RECV,
    ST_SCAN,
    ST_PICK
  } cal_state_e;

  localparam logic [31:0] TEST_WORD = 32'hA5FF005A;

  function automatic logic [7:0] ref_byte(input logic [1:0] lane);
    return TEST_WORD[lane*8 +: 8];
  endfunction
endpackage

// File: rtl/rdcal_burst_cmp.sv
module rdcal_burst_cmp #(
  parameter int BURST_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       fire_i,
  input  logic [7:0] data_i,
  output logic       last_o,
  output logic       pass_o
);
  import rdcal_pkg::*;
  localparam int BW = (BURST_LEN > 4) ? $clog2(BURST_LEN) : 2;

  logic [BW-1:0] beat_q, beat_n;
  logic          bad_q, bad_n;
  logic          byte_ok;

  assign byte_ok = (data_i == ref_byte(beat_q[1:0]));
  assign last_o  = fire_i && (beat_q == BW'(BURST_LEN - 1));
  assign pass_o  = !bad_q && byte_ok;

  always_comb begin
    beat_n = beat_q;
    bad_n  = bad_q;
    if (clr_i) begin
      beat_n = '0;
      bad_n  = 1'b0;
    end else if (fire_i) begin
      beat_n = beat_q + BW'(1);
      bad_n  = bad_q | !byte_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      beat_q <= beat_n;
      bad_q  <= bad_n;
    end
  end
endmodule

// File: rtl/rdcal_run_scan.sv
module rdcal_run_scan #(
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic            bit_i,
  input  logic [CNTW-1:0] idx_i,
  output logic [CNTW-1:0] run_o,
  output logic [CNTW-1:0] max_o,
  output logic [CNTW-1:0] end_o
);
  logic [CNTW-1:0] run_q, run_n, max_q, max_n, end_q, end_n;

  always_comb begin
    run_n = run_q;
    max_n = max_q;
    end_n = end_q;
    if (clr_i) begin
      run_n = '0;
      max_n = '0;
      end_n = '0;
    end else if (step_i) begin
      if (bit_i) begin
        run_n = run_q + CNTW'(1);
      end else begin
        if (run_q > max_q) begin
          max_n = run_q;
          end_n = idx_i - CNTW'(1);
        end
        run_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      max_q <= '0;
      end_q <= '0;
    end else begin
      run_q <= run_n;
      max_q <= max_n;
      end_q <= end_n;
    end
  end

  assign run_o = run_q;
  assign max_o = max_q;
  assign end_o = end_q;
endmodule

// File: rtl/rdcal_pick.sv
module rdcal_pick #(
  parameter int CNTW = 5,
  parameter int IDXW = 4
) (
  input  logic            dbl_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic [IDXW-1:0] dflt_i,
  input  logic [CNTW-1:0] run_i,
  input  logic [CNTW-1:0] max_i,
  input  logic [CNTW-1:0] end_i,
  output logic [IDXW-1:0] idx_o,
  output logic            fail_o
);
  logic [CNTW-1:0] len, endp, pick;

  assign len  = (run_i > max_i) ? run_i : max_i;
  assign endp = (run_i == cnt_i) ? cnt_i : end_i;

  always_comb begin
    pick   = '0;
    fail_o = 1'b0;
    if (dbl_i) begin
      if (len <= CNTW'(2) || len >= CNTW'(6)) begin
        fail_o = 1'b1;
      end else if (len <= CNTW'(4)) begin
        pick = endp - CNTW'(1);
      end else begin
        pick = endp - CNTW'(2);
      end
    end else begin
      if (len <= CNTW'(2) || len >= CNTW'(5)) begin
        fail_o = 1'b1;
      end else begin
        pick = endp - (len >> 1);
      end
    end
    idx_o = fail_o ? dflt_i : pick[IDXW-1:0];
  end
endmodule

// File: rtl/rdcal_engine.sv
module rdcal_engine #(
  parameter int MAX_CAND  = 16,
  parameter int BURST_LEN = 8,
  localparam int IDXW = $clog2(MAX_CAND),
  localparam int CNTW = $clog2(MAX_CAND + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dbl_rate_i,
  input  logic [CNTW-1:0] cand_cnt_i,
  input  logic [IDXW-1:0] dflt_idx_i,
  output logic            rd_req_o,
  output logic [IDXW-1:0] trial_idx_o,
  input  logic            rd_valid_i,
  input  logic [7:0]      rd_data_i,
  output logic            rd_ready_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [IDXW-1:0] sel_idx_o,
  output logic            fail_o
);
  import rdcal_pkg::*;

  cal_state_e          state_q, state_n;
  logic [IDXW-1:0]     cand_q, cand_n, scan_q, scan_n;
  logic [MAX_CAND-1:0] pass_q, pass_n;
  logic [IDXW-1:0]     sel_q, sel_n;
  logic                fail_q, fail_n, done_q, done_n;

  logic            sweep_go, fire, beat_last, cmp_pass;
  logic            cand_last, scan_last;
  logic [CNTW-1:0] run_w, max_w, end_w;
  logic [IDXW-1:0] pick_idx;
  logic            pick_fail;

  assign sweep_go  = (state_q == ST_IDLE) && start_i;
  assign fire      = (state_q == ST_RECV) && rd_valid_i;
  assign cand_last = ({1'b0, cand_q} == cand_cnt_i - CNTW'(1));
  assign scan_last = ({1'b0, scan_q} == cand_cnt_i - CNTW'(1));

  rdcal_burst_cmp #(.BURST_LEN(BURST_LEN)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr_i(state_q == ST_REQ), .fire_i(fire),
    .data_i(rd_data_i), .last_o(beat_last), .pass_o(cmp_pass)
  );

  rdcal_run_scan #(.CNTW(CNTW)) u_scan (
    .clk(clk), .rst_n(rst_n), .clr_i(sweep_go), .step_i(state_q == ST_SCAN),
    .bit_i(pass_q[scan_q]), .idx_i({1'b0, scan_q}),
    .run_o(run_w), .max_o(max_w), .end_o(end_w)
  );

  rdcal_pick #(.CNTW(CNTW), .IDXW(IDXW)) u_pick (
    .dbl_i(dbl_rate_i), .cnt_i(cand_cnt_i), .dflt_i(dflt_idx_i),
    .run_i(run_w), .max_i(max_w), .end_i(end_w),
    .idx_o(pick_idx), .fail_o(pick_fail)
  );

  for (genvar g = 0; g < MAX_CAND; g++) begin : g_pass
    assign pass_n[g] = sweep_go ? 1'b0 :
                       (beat_last && cand_q == IDXW'(g)) ? cmp_pass : pass_q[g];
  end

  always_comb begin
    state_n = state_q;
    cand_n  = cand_q;
    scan_n  = scan_q;
    sel_n   = sel_q;
    fail_n  = fail_q;
    done_n  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_n = ST_REQ;
        cand_n  = '0;
      end
      ST_REQ:  state_n = ST_RECV;
      ST_RECV: if (beat_last) begin
        if (cand_last) begin
          state_n = ST_SCAN;
          scan_n  = '0;
        end else begin
          cand_n  = cand_q + IDXW'(1);
          state_n = ST_REQ;
        end
      end
      ST_SCAN: if (scan_last) state_n = ST_PICK;
               else scan_n = scan_q + IDXW'(1);
      ST_PICK: begin
        sel_n   = pick_idx;
        fail_n  = pick_fail;
        done_n  = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cand_q  <= '0;
      scan_q  <= '0;
      pass_q  <= '0;
      sel_q   <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cand_q  <= cand_n;
      scan_q  <= scan_n;
      pass_q  <= pass_n;
      sel_q   <= sel_n;
      fail_q  <= fail_n;
      done_q  <= done_n;
    end
  end

  assign rd_req_o    = (state_q == ST_REQ);
  assign rd_ready_o  = (state_q == ST_RECV);
  assign trial_idx_o = cand_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign sel_idx_o   = sel_q;
  assign fail_o      = fail_q;
endmodule

// File: rtl/rdcal_engine_chk.sv
module rdcal_engine_chk #(
  parameter int MAX_CAND = 16,
  localparam int IDXW = $clog2(MAX_CAND),
  localparam int CNTW = $clog2(MAX_CAND + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CNTW-1:0] cand_cnt_i,
  input logic [IDXW-1:0] dflt_idx_i,
  input logic            rd_req_o,
  input logic [IDXW-1:0] trial_idx_o,
  input logic            rd_ready_o,
  input logic            busy_o,
  input logic            done_o,
  input logic [IDXW-1:0] sel_idx_o,
  input logic            fail_o
);
  assert_req_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> ({1'b0, trial_idx_o} < cand_cnt_i));

  assert_req_then_recv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> (rd_ready_o && !rd_req_o));

  assert_ready_in_sweep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready_o |-> (busy_o && !rd_req_o));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(sel_idx_o) && $stable(fail_o)));

  // covers both R6 and R7 fallback
  assert_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fail_o) |-> (sel_idx_o == dflt_idx_i));
endmodule

bind rdcal_engine rdcal_engine_chk #(.MAX_CAND(MAX_CAND)) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_cnt_i(cand_cnt_i), .dflt_idx_i(dflt_idx_i),
  .rd_req_o(rd_req_o), .trial_idx_o(trial_idx_o), .rd_ready_o(rd_ready_o),
  .busy_o(busy_o), .done_o(done_o), .sel_idx_o(sel_idx_o), .fail_o(fail_o)
);

// File: tb/rdcal_engine_bench.sv
module rdcal_engine_bench;
  localparam int MAXC = 16;
  localparam int BL   = 8;
  localparam int IDXW = 4;
  localparam int CNTW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n, start_i, dbl_rate_i, rd_valid_i;
  logic [CNTW-1:0] cand_cnt_i;
  logic [IDXW-1:0] dflt_idx_i;
  logic [7:0]      rd_data_i;
  logic            rd_req_o, rd_ready_o, busy_o, done_o, fail_o;
  logic [IDXW-1:0] trial_idx_o, sel_idx_o;

  rdcal_engine #(.MAX_CAND(MAXC), .BURST_LEN(BL)) u_rdcal_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_rate_i(dbl_rate_i),
    .cand_cnt_i(cand_cnt_i), .dflt_idx_i(dflt_idx_i), .rd_req_o(rd_req_o),
    .trial_idx_o(trial_idx_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .rd_ready_o(rd_ready_o), .busy_o(busy_o), .done_o(done_o),
    .sel_idx_o(sel_idx_o), .fail_o(fail_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  bit mon_en = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b);
    case (b % 4)
      0: return 8'h5A;
      1: return 8'h00;
      2: return 8'hFF;
      default: return 8'hA5;
    endcase
  endfunction

  // behavioural reference model
  int   ph, m_cand, m_beat, m_tail, m_sel;
  bit   m_ok, m_fail;
  bit   m_pass[MAXC];
  string m_tag;

  task automatic model_pick();
    int n, cur, best, e, len, ep, s;
    bit fl, allp;
    n = int'(cand_cnt_i); cur = 0; best = 0; e = 0; allp = 1;
    for (int i = 0; i < n; i++) begin
      if (m_pass[i]) cur++;
      else begin
        allp = 0;
        if (cur > best) begin best = cur; e = i - 1; end
        cur = 0;
      end
    end
    len = (cur > best) ? cur : best;
    ep  = allp ? n : e;
    fl = 0; s = 0;
    if (dbl_rate_i) begin
      if (len <= 2 || len >= 6) fl = 1;
      else if (len <= 4) s = ep - 1;
      else s = ep - 2;
    end else begin
      if (len <= 2 || len >= 5) fl = 1;
      else s = ep - len / 2;
    end
    m_fail = fl;
    m_sel  = fl ? int'(dflt_idx_i) : (s & 15);
    m_tag  = allp ? "R5" : (dbl_rate_i ? "R6" : "R7");
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_cand = 0; m_beat = 0; m_tail = 0; m_sel = 0; m_fail = 0; m_ok = 1;
      m_tag = "R1";
      for (int i = 0; i < MAXC; i++) m_pass[i] = 0;
    end else begin
      case (ph)
        0, 4: if (start_i) begin
          ph = 1; m_cand = 0;
          for (int i = 0; i < MAXC; i++) m_pass[i] = 0;
        end else ph = 0;
        1: begin ph = 2; m_beat = 0; m_ok = 1; end
        2: if (rd_valid_i) begin
          if (rd_data_i != pat(m_beat)) m_ok = 0;
          m_beat++;
          if (m_beat == BL) begin
            m_pass[m_cand] = m_ok;
            if (m_cand == int'(cand_cnt_i) - 1) begin ph = 3; m_tail = int'(cand_cnt_i) + 1; end
            else begin m_cand++; ph = 1; end
          end
        end
        default: begin
          m_tail--;
          if (m_tail == 0) begin ph = 4; model_pick(); end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      chk(busy_o == (ph >= 1 && ph <= 3), "R2 busy", busy_o, (ph >= 1 && ph <= 3));
      chk(rd_req_o == (ph == 1), "R2 req", rd_req_o, ph == 1);
      if (ph == 1) chk(int'(trial_idx_o) == m_cand, "R2 trial_idx", trial_idx_o, m_cand);
      chk(rd_ready_o == (ph == 2), "R3 ready", rd_ready_o, ph == 2);
      chk(done_o == (ph == 4), "R8 done", done_o, ph == 4);
      chk(int'(sel_idx_o) == m_sel, (ph == 4) ? m_tag : "R8 hold", sel_idx_o, m_sel);
      chk(fail_o == m_fail, (ph == 4) ? m_tag : "R8 hold", fail_o, m_fail);
    end
  end

  // drive one sweep; candidates whose bit in mask is 0 get one corrupted beat
  task automatic sweep(input int n, input bit dbl, input int dflt,
                       input logic [15:0] mask, input bit gaps, input bit hold_start);
    int t = 0;
    @(negedge clk);
    cand_cnt_i = CNTW'(n); dbl_rate_i = dbl; dflt_idx_i = IDXW'(dflt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = hold_start;
    for (int c = 0; c < n; c++) begin
      int b = 0;
      while (b < BL) begin
        @(negedge clk);
        if (c > 0) start_i = 1'b0;
        t++;
        if (rd_ready_o && !(gaps && (t % 3 == 2))) begin
          rd_valid_i = 1'b1;
          rd_data_i  = pat(b) ^ ((!mask[c] && b == (c % BL)) ? 8'h01 : 8'h00);
          b++;
        end else begin
          rd_valid_i = 1'b0;
          rd_data_i  = 8'h33;
        end
      end
    end
    @(negedge clk);
    rd_valid_i = 1'b0;
    start_i = 1'b0;
    repeat (n + 4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; dbl_rate_i = 1'b1; rd_valid_i = 1'b0;
    rd_data_i = 8'h00; cand_cnt_i = CNTW'(8); dflt_idx_i = IDXW'(9);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !rd_req_o && !rd_ready_o, "R1 controls", busy_o, 0);
    chk(sel_idx_o == 0 && !fail_o, "R1 result", sel_idx_o, 0);
    mon_en = 1'b1;
    sweep(8, 1, 9, 16'h001C, 0, 0);   // R6 len3 -> end-1
    sweep(8, 1, 9, 16'h003E, 1, 1);   // R6 len5 -> end-2, R2 start held ignored
    sweep(8, 1, 9, 16'h007E, 0, 0);   // R6 len6 fallback
    sweep(8, 1, 9, 16'h0006, 1, 0);   // R6 len2 fallback
    sweep(8, 0, 7, 16'h003C, 0, 0);   // R7 len4
    sweep(8, 0, 7, 16'h0070, 1, 0);   // R7 len3
    sweep(8, 0, 7, 16'h00F8, 0, 0);   // R7 len5 fallback
    sweep(5, 1, 9, 16'h001F, 0, 0);   // R5 all pass, double-rate
    sweep(4, 0, 2, 16'h000F, 1, 0);   // R5 all pass, single-rate
    sweep(7, 1, 9, 16'h0073, 0, 0);   // R4 trailing longest keeps old end
    sweep(10, 1, 9, 16'h00E7, 0, 0);  // R4 equal later run does not replace
    sweep(16, 1, 11, 16'h0000, 1, 0); // R3 all fail, rest of bursts consumed
    sweep(6, 0, 3, 16'h0038, 0, 0);   // R9 fresh pass bits after prior sweeps
    mon_en = 1'b0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule